// File: doc/BRIEF.md
# Transmit Command and Status Register

This block is the transmit-side control and status word of a multi-protocol serial controller. A software write carries a 4-bit command in its top nibble. The block turns that command into a single-clock strobe for the transmitter: clear the CRC generator, start or abort a frame, switch transparent-mode DLE stuffing on or off, or set or clear the end-of-message marker. Commands that only make sense in one protocol family are gated by the current protocol mode. A small group of commands instead chooses what a neighbouring interrupt-control register shows in its upper byte. That choice is held here as a 2-bit select.

The same write also loads an idle-line pattern select and an underrun-wait interlock bit. It can clear any of six sticky event flags by writing 1 to that flag's position. The transmitter raises these flags with single-cycle pulses. Reads return the interlock, the idle select, the latched flags and two live levels: line drained and FIFO empty. The command nibble always reads as zero.

Top module: `tx_cmd_stat`

## Requirements
- R1: While `rstN` is low, and right after it is released, `rdData` shows only the live bits. The idle select, the interlock, all sticky flags and `intSel` are zero, and no strobe is high.
- R2: A write with command 0010 raises `clrCrcStb` in the cycle after the write, for exactly one clock, in every protocol mode.
- R3: Commands 0101, 0110 and 0111 load `intSel` with 0 (FIFO status), 1 (interrupt line level) and 2 (DMA request level) respectively. The value holds until another of these commands arrives. It never becomes 3.
- R4: Commands 1000 (send frame) and 1001 (send abort) raise `sendFrameStb` and `sendAbortStb` only when `protoMode` is 01 (bit-oriented framing). In any other mode they produce no strobe.
- R5: Commands 1100 and 1101 raise `dleOnStb` and `dleOffStb` only when `protoMode` is 10 (transparent byte-sync).
- R6: Commands 1110 and 1111 raise `eomClrStb` and `eomSetStb` in any synchronous mode (`protoMode` 01, 10 or 11). They do nothing in mode 00 (async).
- R7: Commands 0000, 0001, 0011, 0100, 1010 and 1011 produce no strobe and leave `intSel` unchanged. At most one strobe is high in any cycle.
- R8: Every write loads bits 10..8 as the idle select and bit 11 as the underrun-wait interlock. Both read back at those positions and drive `idleSel` and `underWait`.
- R9: The sticky flags sit at these `rdData` positions: preamble sent at bit 7, idle sent at 6, abort sent at 5, end-of-message sent at 4, CRC sent at 3, and underflow at 1. A one-cycle pulse on the matching `ev*` input sets the flag in the next cycle. The flag then holds.
- R10: Writing 1 to a sticky flag's position clears it, and writing 0 leaves it alone. If the flag's event pulse arrives in the same cycle as the clear, the flag ends up set.
- R11: `rdData` bit 2 follows `lineDrained` and bit 0 follows `fifoEmpty` in the same cycle. Writes have no effect on them.
- R12: `rdData` bits 15..12 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for `wrData` |
| wrData | input | 16 | Write word: command, interlock, idle select, clear mask |
| protoMode | input | 2 | 00 async, 01 bit-oriented, 10 transparent byte-sync, 11 other char-sync |
| evPreamble | input | 1 | Pulse: preamble finished |
| evIdle | input | 1 | Pulse: idle condition sent |
| evAbort | input | 1 | Pulse: abort sent |
| evEom | input | 1 | Pulse: end of frame/message sent |
| evCrc | input | 1 | Pulse: CRC sent |
| evUnderflow | input | 1 | Pulse: transmitter underflowed |
| lineDrained | input | 1 | Level: last bit has left the line |
| fifoEmpty | input | 1 | Level: transmit FIFO empty |
| rdData | output | 16 | Read word |
| idleSel | output | 3 | Idle-line pattern select |
| underWait | output | 1 | Underrun-wait interlock |
| intSel | output | 2 | Upper-byte source for the interrupt-control register |
| clrCrcStb | output | 1 | Strobe: clear CRC generator |
| sendFrameStb | output | 1 | Strobe: send frame |
| sendAbortStb | output | 1 | Strobe: send abort |
| dleOnStb | output | 1 | Strobe: enable DLE insertion |
| dleOffStb | output | 1 | Strobe: disable DLE insertion |
| eomClrStb | output | 1 | Strobe: clear end-of-message |
| eomSetStb | output | 1 | Strobe: set end-of-message |

## Verification
The bench's reference model compares every output on every clock, so a wrong internal state shows up at the ports quickly. A sticky flag that was lost, or never cleared, is visible on `rdData` one cycle after the pulse or write that should have changed it. A wrong command decode shows as a missing, extra or mode-ungated strobe in the cycle after the write. A bad `intSel` register keeps showing its wrong value on every following cycle until the next select command.

// File: rtl/tx_csr_pkg.sv
package tx_csr_pkg;
  localparam int DATA_W     = 16;
  localparam int CMD_W      = 4;
  localparam int CMD_LSB    = DATA_W - CMD_W;
  localparam int WAIT_BIT   = 11;
  localparam int IDLE_W     = 3;
  localparam int IDLE_LSB   = 8;
  localparam int NUM_STICKY = 6;
  localparam int SEL_W      = 2;
  localparam int LIVE_DRAIN = 2;
  localparam int LIVE_EMPTY = 0;

  typedef enum logic [1:0] {
    MODE_ASYNC   = 2'b00,
    MODE_BITSYNC = 2'b01,
    MODE_TRANSP  = 2'b10,
    MODE_CHARSYN = 2'b11
  } protoMode_e;

  typedef struct packed {
    logic clrCrc;
    logic sendFrame;
    logic sendAbort;
    logic dleOn;
    logic dleOff;
    logic eomClr;
    logic eomSet;
  } cmdStb_t;

  // Sticky index 0..4 -> bits 3..7, index 5 -> bit 1 (underflow)
  function automatic int stickyPos(input int idx);
    return (idx < 5) ? (3 + idx) : 1;
  endfunction
endpackage

// File: rtl/tx_csr_ctrl.sv
module tx_csr_ctrl
  import tx_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [CMD_W-1:0]     cmdCode,
  input  logic [1:0]           protoMode,
  output cmdStb_t              stbQ,
  output logic [SEL_W-1:0]     intSelQ
);
  protoMode_e modeE;
  cmdStb_t    stbD;
  logic       selLoad;
  logic [SEL_W-1:0] selD;
  logic isBitSync, isTransp, isSync;

  assign modeE     = protoMode_e'(protoMode);
  assign isBitSync = (modeE == MODE_BITSYNC);
  assign isTransp  = (modeE == MODE_TRANSP);
  assign isSync    = (modeE != MODE_ASYNC);

  always_comb begin
    stbD    = '0;
    selLoad = 1'b0;
    selD    = intSelQ;
    if (wrEn) begin
      case (cmdCode)
        4'b0010: stbD.clrCrc = 1'b1;
        4'b0101: begin selLoad = 1'b1; selD = 2'd0; end
        4'b0110: begin selLoad = 1'b1; selD = 2'd1; end
        4'b0111: begin selLoad = 1'b1; selD = 2'd2; end
        4'b1000: stbD.sendFrame = isBitSync;
        4'b1001: stbD.sendAbort = isBitSync;
        4'b1100: stbD.dleOn     = isTransp;
        4'b1101: stbD.dleOff    = isTransp;
        4'b1110: stbD.eomClr    = isSync;
        4'b1111: stbD.eomSet    = isSync;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbQ    <= '0;
      intSelQ <= '0;
    end else begin
      stbQ <= stbD;
      if (selLoad) intSelQ <= selD;
    end
  end

  // R7
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbQ));
  // R7
  stb_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stbQ) |-> $past(wrEn));
  // R4
  frame_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbQ.sendFrame || stbQ.sendAbort) |-> ($past(protoMode) == 2'b01));
  // R5
  dle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbQ.dleOn || stbQ.dleOff) |-> ($past(protoMode) == 2'b10));
  // R6
  eom_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stbQ.eomClr || stbQ.eomSet) |-> ($past(protoMode) != 2'b00));
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(intSelQ));
  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    intSelQ != 2'd3);
endmodule

// File: rtl/tx_csr_dp.sv
module tx_csr_dp
  import tx_csr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_STICKY-1:0] evVec,
  input  logic                  lineDrained,
  input  logic                  fifoEmpty,
  output logic [DATA_W-1:0]     rdData,
  output logic [IDLE_W-1:0]     idleSelQ,
  output logic                  underWaitQ
);
  logic [NUM_STICKY-1:0] stickyQ;
  logic [NUM_STICKY-1:0] clrMask;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[DATA_W-1:CMD_LSB], wrData[LIVE_DRAIN], wrData[LIVE_EMPTY]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleSelQ   <= '0;
      underWaitQ <= 1'b0;
    end else if (wrEn) begin
      idleSelQ   <= wrData[IDLE_LSB +: IDLE_W];
      underWaitQ <= wrData[WAIT_BIT];
    end
  end

  for (genvar gi = 0; gi < NUM_STICKY; gi++) begin : gSticky
    localparam int POS = stickyPos(gi);
    assign clrMask[gi] = wrEn && wrData[POS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             stickyQ[gi] <= 1'b0;
      else if (evVec[gi])    stickyQ[gi] <= 1'b1;
      else if (clrMask[gi])  stickyQ[gi] <= 1'b0;
    end

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      evVec[gi] |=> rdData[POS]);
    // R10
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrData[POS] && !evVec[gi]) |=> !rdData[POS]);
    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!evVec[gi] && !(wrEn && wrData[POS])) |=> $stable(stickyQ[gi]));
  end

  always_comb begin
    rdData = '0;
    rdData[WAIT_BIT] = underWaitQ;
    rdData[IDLE_LSB +: IDLE_W] = idleSelQ;
    for (int k = 0; k < NUM_STICKY; k++) rdData[stickyPos(k)] = stickyQ[k];
    rdData[LIVE_DRAIN] = lineDrained;
    rdData[LIVE_EMPTY] = fifoEmpty;
  end

  // R12
  cmd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:CMD_LSB] == '0);
  // R8
  field_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (idleSelQ == $past(wrData[IDLE_LSB +: IDLE_W])));
endmodule

// File: rtl/tx_cmd_stat.sv
module tx_cmd_stat
  import tx_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic [1:0]  protoMode,
  input  logic        evPreamble,
  input  logic        evIdle,
  input  logic        evAbort,
  input  logic        evEom,
  input  logic        evCrc,
  input  logic        evUnderflow,
  input  logic        lineDrained,
  input  logic        fifoEmpty,
  output logic [15:0] rdData,
  output logic [2:0]  idleSel,
  output logic        underWait,
  output logic [1:0]  intSel,
  output logic        clrCrcStb,
  output logic        sendFrameStb,
  output logic        sendAbortStb,
  output logic        dleOnStb,
  output logic        dleOffStb,
  output logic        eomClrStb,
  output logic        eomSetStb
);
  cmdStb_t stb;
  logic [NUM_STICKY-1:0] evVec;

  assign evVec = {evUnderflow, evPreamble, evIdle, evAbort, evEom, evCrc};

  tx_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .cmdCode(wrData[DATA_W-1:CMD_LSB]), .protoMode(protoMode),
    .stbQ(stb), .intSelQ(intSel)
  );

  tx_csr_dp u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .evVec(evVec), .lineDrained(lineDrained), .fifoEmpty(fifoEmpty),
    .rdData(rdData), .idleSelQ(idleSel), .underWaitQ(underWait)
  );

  assign clrCrcStb    = stb.clrCrc;
  assign sendFrameStb = stb.sendFrame;
  assign sendAbortStb = stb.sendAbort;
  assign dleOnStb     = stb.dleOn;
  assign dleOffStb    = stb.dleOff;
  assign eomClrStb    = stb.eomClr;
  assign eomSetStb    = stb.eomSet;
endmodule

// File: tb/test_tx_cmd_stat.sv
`timescale 1ns/1ps
module test_tx_cmd_stat;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sWr = 1'b0;
  logic [15:0] sData = '0;
  logic [1:0] sMode = '0;
  logic [5:0] sEv = '0;  // [5]preamble [4]idle [3]abort [2]eom [1]crc [0]underflow
  logic sLd = 1'b0, sFe = 1'b1;

  logic [15:0] rdData;
  logic [2:0] idleSel;
  logic underWait;
  logic [1:0] intSel;
  logic clrCrcStb, sendFrameStb, sendAbortStb, dleOnStb, dleOffStb, eomClrStb, eomSetStb;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_cmd_stat i_tx_cmd_stat (
    .clk(clk), .rstN(rstN), .wrEn(sWr), .wrData(sData), .protoMode(sMode),
    .evPreamble(sEv[5]), .evIdle(sEv[4]), .evAbort(sEv[3]), .evEom(sEv[2]),
    .evCrc(sEv[1]), .evUnderflow(sEv[0]), .lineDrained(sLd), .fifoEmpty(sFe),
    .rdData(rdData), .idleSel(idleSel), .underWait(underWait), .intSel(intSel),
    .clrCrcStb(clrCrcStb), .sendFrameStb(sendFrameStb), .sendAbortStb(sendAbortStb),
    .dleOnStb(dleOnStb), .dleOffStb(dleOffStb), .eomClrStb(eomClrStb), .eomSetStb(eomSetStb)
  );

  // Reference model state
  logic [15:0] mStick = '0;
  logic [2:0]  mIdle = '0;
  logic        mWait = 1'b0;
  logic [1:0]  mSel = '0;
  logic [6:0]  mStb = '0; // clrCrc,frame,abort,dleOn,dleOff,eomClr,eomSet

  always @(posedge clk) begin
    if (!rstN) begin
      mStick = '0; mIdle = '0; mWait = 1'b0; mSel = '0; mStb = '0;
    end else begin
      logic [15:0] evMask, clr;
      evMask = '0;
      evMask[7] = sEv[5]; evMask[6] = sEv[4]; evMask[5] = sEv[3];
      evMask[4] = sEv[2]; evMask[3] = sEv[1]; evMask[1] = sEv[0];
      clr = sWr ? (sData & 16'h00FA) : 16'h0000;
      mStick = evMask | (mStick & ~clr);
      mStb = '0;
      if (sWr) begin
        mIdle = sData[10:8];
        mWait = sData[11];
        case (sData[15:12])
          4'd2:  mStb[6] = 1'b1;
          4'd5:  mSel = 2'd0;
          4'd6:  mSel = 2'd1;
          4'd7:  mSel = 2'd2;
          4'd8:  mStb[5] = (sMode == 2'd1);
          4'd9:  mStb[4] = (sMode == 2'd1);
          4'd12: mStb[3] = (sMode == 2'd2);
          4'd13: mStb[2] = (sMode == 2'd2);
          4'd14: mStb[1] = (sMode != 2'd0);
          4'd15: mStb[0] = (sMode != 2'd0);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [15:0] expRd;
    expRd = mStick | {4'b0, mWait, mIdle, 8'b0} | {13'b0, sLd, 1'b0, sFe};
    check("R12 cmd nibble", rdData[15:12], 0);
    check("R8 fields", {rdData[11:8], underWait, idleSel}, {expRd[11:8], mWait, mIdle});
    check("R9 R10 sticky", rdData & 16'h00FA, expRd & 16'h00FA);
    check("R11 live", {rdData[2], rdData[0]}, {sLd, sFe});
    check("R3 intSel", intSel, mSel);
    check("R2 clrCrc", clrCrcStb, mStb[6]);
    check("R4 frame/abort", {sendFrameStb, sendAbortStb}, mStb[5:4]);
    check("R5 dle", {dleOnStb, dleOffStb}, mStb[3:2]);
    check("R6 eom", {eomClrStb, eomSetStb}, mStb[1:0]);
    // R7: reserved codes leave all strobes low, compared above
  endtask

  task automatic step(input logic wr, input logic [15:0] d, input logic [1:0] m,
                      input logic [5:0] ev, input logic ld, input logic fe);
    @(negedge clk);
    compareAll();
    sWr = wr; sData = d; sMode = m; sEv = ev; sLd = ld; sFe = fe;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd in reset", rdData, 16'h0001);
    check("R1 strobes in reset", {clrCrcStb, sendFrameStb, sendAbortStb, dleOnStb,
          dleOffStb, eomClrStb, eomSetStb, intSel}, 0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 1);
    // R2 R3 R4 R5 R6 R7: every command in every mode, with a gap cycle
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 16; c++) begin
        step(1, {c[3:0], 12'h000}, m[1:0], 0, 0, 1);
        step(0, 0, m[1:0], 0, 0, 1);
      end
    // R8: field writes
    step(1, 16'h0B00, 1, 0, 1, 0);
    step(1, 16'h0500, 1, 0, 0, 1);
    // R9: set every flag, then R10 clear with zero mask has no effect
    step(0, 0, 1, 6'h3F, 0, 0);
    step(1, 16'h0000, 1, 0, 1, 1);
    // R10: W1C and set in the same cycle -> set wins; bit 2/0 writes ignored (R11)
    step(1, 16'h00FF, 1, 6'h3F, 0, 1);
    step(1, 16'h00FF, 1, 6'h21, 1, 0);
    step(1, 16'h00FF, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    // back-to-back commands
    step(1, 16'h2000, 1, 0, 0, 1);
    step(1, 16'h8000, 1, 0, 0, 1);
    step(1, 16'h9000, 1, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [5:0] ev;
      wr = ($urandom % 3) == 0;
      for (int b = 0; b < 6; b++) ev[b] = ($urandom % 8) == 0;
      step(wr, 16'($urandom), 2'($urandom), ev, 1'($urandom), 1'($urandom));
    end
    step(0, 0, 0, 0, 0, 1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule